// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits in a host bridge, between the processor-side I/O windows and the PCI bus engine. When the processor touches a window programmed as I/O space, the block reads a 32-bit configuration address register and decides what the access becomes on PCI. The four outcomes are a Type 0 configuration cycle aimed at a device on the local bus, a Type 1 configuration cycle forwarded to a bus behind a bridge, a hand-off to the special-cycle / interrupt-acknowledge path, or an ordinary I/O transfer. Accesses to memory-programmed windows are never translated.

For configuration cycles the block forms the AD[31:0] value for the address phase and the bus command. For every translated access it forms the four active-high byte enables from the access size and byte offset. It registers the result and holds it until the bus engine acknowledges the address phase. The window remapping of pass-through I/O, the data phases and the bus protocol itself belong to other blocks.

Top module: `pci_cfg_xlate`

## Requirements
- R1: After reset `ap_valid` is 0 and `ap_kind`, `ap_ad`, `ap_cmd` and `ap_be` are all zero.
- R2: A request with `req_io_win` = 0 (memory window) is never translated: `ap_valid` stays 0 after it.
- R3: With the enable flag (`cfg_addr[31]`) clear, an accepted request yields kind 3 (I/O pass-through), with `ap_ad` = 0 and `ap_cmd` = 0000.
- R4: With the enable flag set and the device field (`cfg_addr[15:11]`) equal to 31, the kind is 2 (special / interrupt acknowledge) whatever the bus field holds, with `ap_ad` = 0 and `ap_cmd` = 0000.
- R5: With the enable flag set, device below 31 and bus field (`cfg_addr[23:16]`) zero, the kind is 0 (Type 0): `ap_ad[10:8]` = function (`cfg_addr[10:8]`), `ap_ad[7:2]` = dword (`cfg_addr[7:2]`), `ap_ad[1:0]` = 00.
- R6: In a Type 0 address phase, device d from 10 to 30 drives only line AD[41-d] high among AD[31:11] (device 10 on AD31, device 30 on AD11); devices 0 to 9 drive none of AD[31:11].
- R7: With the enable flag set, device below 31 and bus field nonzero, the kind is 1 (Type 1): `ap_ad[31:24]` = 0, `ap_ad[23:2]` = `cfg_addr[23:2]`, `ap_ad[1:0]` = 01.
- R8: For kinds 0 and 1, `ap_cmd` is 1010 for a read (`req_write` = 0) and 1011 for a write.
- R9: `ap_be` (bit i enables byte lane i) follows `req_size` and `req_offset`: size 0 (byte) gives 1 << offset; size 1 (half) gives 0011 when offset[1] = 0 and 1100 otherwise; sizes 2 and 3 give 1111.
- R10: Once `ap_valid` is 1, all outputs hold unchanged until a cycle with `ap_ack` = 1; `ap_valid` is 0 in the cycle after that. `req_ready` is the inverse of `ap_valid`, so any request offered while `ap_valid` is 1 is dropped, and so is one offered in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 32 | Configuration address register contents |
| req_valid | input | 1 | Local window access present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io_win | input | 1 | Accessed window is programmed as I/O space |
| req_size | input | 2 | 0 byte, 1 half, 2 or 3 word |
| req_offset | input | 2 | Byte offset within the dword |
| req_ready | output | 1 | Block can take a request this cycle |
| ap_ack | input | 1 | Bus engine has taken the address phase |
| ap_valid | output | 1 | Address-phase outputs are valid |
| ap_kind | output | 2 | 0 Type 0, 1 Type 1, 2 special, 3 I/O pass-through |
| ap_ad | output | 32 | AD value for the address phase |
| ap_cmd | output | 4 | PCI bus command |
| ap_be | output | 4 | Active-high byte enables |

## Verification
The acknowledge of a held address phase and the arrival of a fresh request can land on the same clock edge. The bench offers a request with a different register value in exactly the cycle it raises `ap_ack`. It then expects `ap_valid` low one cycle later, showing the new request was dropped and not loaded over the departing one. It also holds each result for an extra cycle without an acknowledge and compares every output against the first sample.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  typedef enum logic [1:0] {
    KIND_CFG0    = 2'd0,
    KIND_CFG1    = 2'd1,
    KIND_SPECIAL = 2'd2,
    KIND_IOPASS  = 2'd3
  } ap_kind_e;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [3:0] CMD_NONE   = 4'b0000;

  // Decoded fields of the configuration address register
  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_fields_t;

  // Byte-lane enables from access size and offset
  function automatic logic [3:0] lanes_for(input logic [1:0] size, input logic [1:0] off);
    logic [3:0] r;
    case (size)
      2'd0:    r = 4'b0001 << off;
      2'd1:    r = off[1] ? 4'b1100 : 4'b0011;
      default: r = 4'b1111;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
  import pci_cfg_pkg::*;
#(
  parameter int unsigned SPECIAL_DEV = 31
) (
  input  cfg_fields_t fields,
  input  logic        is_write,
  output ap_kind_e    kind,
  output logic        is_cfg,
  output logic [3:0]  cmd
);

  logic special_hit;
  logic local_bus;

  assign special_hit = (fields.dev == 5'(SPECIAL_DEV));
  assign local_bus   = (fields.bus == 8'h00);

  always_comb begin
    if (!fields.en)       kind = KIND_IOPASS;
    else if (special_hit) kind = KIND_SPECIAL;
    else if (local_bus)   kind = KIND_CFG0;
    else                  kind = KIND_CFG1;
  end

  assign is_cfg = (kind == KIND_CFG0) || (kind == KIND_CFG1);
  assign cmd    = !is_cfg ? CMD_NONE : (is_write ? CMD_CFG_WR : CMD_CFG_RD);

endmodule

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen
  import pci_cfg_pkg::*;
#(
  parameter int unsigned IDSEL_FIRST_DEV = 10,
  parameter int unsigned IDSEL_LINES     = 21
) (
  input  cfg_fields_t  fields,
  input  ap_kind_e     kind,
  output logic [31:0]  ad,
  output logic [IDSEL_LINES-1:0] idsel
);

  localparam int unsigned LOW_BITS = 3 + 6 + 2;

  // idsel[IDSEL_LINES-1] is the top AD line; device numbers rise downward
  for (genvar g = 0; g < IDSEL_LINES; g++) begin : g_idsel
    assign idsel[IDSEL_LINES-1-g] = (fields.dev == 5'(IDSEL_FIRST_DEV + g));
  end

  logic [31:0] ad_type0;
  logic [31:0] ad_type1;

  if (IDSEL_LINES + LOW_BITS == 32) begin : g_full
    assign ad_type0 = {idsel, fields.fn, fields.dw, 2'b00};
  end else begin : g_part
    assign ad_type0 = {{(32-IDSEL_LINES-LOW_BITS){1'b0}}, idsel, fields.fn, fields.dw, 2'b00};
  end

  assign ad_type1 = {8'h00, fields.bus, fields.dev, fields.fn, fields.dw, 2'b01};

  always_comb begin
    case (kind)
      KIND_CFG0: ad = ad_type0;
      KIND_CFG1: ad = ad_type1;
      default:   ad = 32'h0;
    endcase
  end

endmodule

// File: rtl/pci_cfg_be_gen.sv
module pci_cfg_be_gen
  import pci_cfg_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] offset,
  output logic [3:0] be
);

  assign be = lanes_for(size, offset);

endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import pci_cfg_pkg::*;
#(
  parameter int unsigned SPECIAL_DEV     = 31,
  parameter int unsigned IDSEL_FIRST_DEV = 10,
  parameter int unsigned IDSEL_LINES     = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_addr,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_io_win,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_offset,
  output logic        req_ready,
  input  logic        ap_ack,
  output logic        ap_valid,
  output logic [1:0]  ap_kind,
  output logic [31:0] ap_ad,
  output logic [3:0]  ap_cmd,
  output logic [3:0]  ap_be
);

  cfg_fields_t fields;
  logic        unused_rsv;

  assign fields.en  = cfg_addr[31];
  assign fields.bus = cfg_addr[23:16];
  assign fields.dev = cfg_addr[15:11];
  assign fields.fn  = cfg_addr[10:8];
  assign fields.dw  = cfg_addr[7:2];
  assign unused_rsv = ^{cfg_addr[30:24], cfg_addr[1:0]};

  ap_kind_e                 nxt_kind;
  logic                     nxt_is_cfg;
  logic [3:0]               nxt_cmd;
  logic [31:0]              nxt_ad;
  logic [3:0]               nxt_be;
  logic [IDSEL_LINES-1:0]   nxt_idsel;

  pci_cfg_decode #(.SPECIAL_DEV(SPECIAL_DEV)) i_decode (
    .fields   (fields),
    .is_write (req_write),
    .kind     (nxt_kind),
    .is_cfg   (nxt_is_cfg),
    .cmd      (nxt_cmd)
  );

  pci_cfg_addr_gen #(
    .IDSEL_FIRST_DEV (IDSEL_FIRST_DEV),
    .IDSEL_LINES     (IDSEL_LINES)
  ) i_addr (
    .fields (fields),
    .kind   (nxt_kind),
    .ad     (nxt_ad),
    .idsel  (nxt_idsel)
  );

  pci_cfg_be_gen i_be (
    .size   (req_size),
    .offset (req_offset),
    .be     (nxt_be)
  );

  // Named events for the checker
  logic accept_w;
  logic ack_fire_w;
  logic unused_dbg;

  assign req_ready  = !ap_valid;
  assign accept_w   = req_valid && req_ready && req_io_win;
  assign ack_fire_w = ap_valid && ap_ack;
  assign unused_dbg = nxt_is_cfg ^ (^nxt_idsel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_valid <= 1'b0;
      ap_kind  <= 2'd0;
      ap_ad    <= 32'h0;
      ap_cmd   <= 4'h0;
      ap_be    <= 4'h0;
    end else if (accept_w) begin
      ap_valid <= 1'b1;
      ap_kind  <= nxt_kind;
      ap_ad    <= nxt_ad;
      ap_cmd   <= nxt_cmd;
      ap_be    <= nxt_be;
    end else if (ack_fire_w) begin
      ap_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pci_cfg_xlate_chk.sv
module pci_cfg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_io_win,
  input logic        ap_ack,
  input logic        ap_valid,
  input logic [1:0]  ap_kind,
  input logic [31:0] ap_ad,
  input logic [3:0]  ap_cmd,
  input logic [3:0]  ap_be,
  input logic        accept_w
);

  p_rst_idle_r1: assert property (@(posedge clk) !rst_n |=> !ap_valid);

  p_mem_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ap_valid && req_valid && !req_io_win) |=> !ap_valid);

  p_noncfg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && ap_kind[1]) |-> (ap_ad == 32'h0 && ap_cmd == 4'h0));

  p_idsel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && ap_kind == 2'd0) |-> ($onehot0(ap_ad[31:11]) && ap_ad[1:0] == 2'b00));

  p_type1_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && ap_kind == 2'd1) |-> (ap_ad[31:24] == 8'h0 && ap_ad[1:0] == 2'b01));

  p_cfg_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && !ap_kind[1]) |-> (ap_cmd[3:1] == 3'b101));

  p_be_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ap_valid |-> (ap_be != 4'h0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && !ap_ack) |=> (ap_valid && $stable(ap_ad) && $stable(ap_cmd)
                               && $stable(ap_be) && $stable(ap_kind)));

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && ap_ack) |=> !ap_valid);

  p_accept_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> ap_valid);

endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_io_win (req_io_win),
  .ap_ack     (ap_ack),
  .ap_valid   (ap_valid),
  .ap_kind    (ap_kind),
  .ap_ad      (ap_ad),
  .ap_cmd     (ap_cmd),
  .ap_be      (ap_be),
  .accept_w   (accept_w)
);

// File: tb/test_pci_cfg_xlate.sv
module test_pci_cfg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_addr = 32'h0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_io_win = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [1:0]  req_offset = 2'd0;
  logic        req_ready;
  logic        ap_ack = 1'b0;
  logic        ap_valid;
  logic [1:0]  ap_kind;
  logic [31:0] ap_ad;
  logic [3:0]  ap_cmd;
  logic [3:0]  ap_be;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pci_cfg_xlate i_pci_cfg_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .req_valid(req_valid),
    .req_write(req_write), .req_io_win(req_io_win), .req_size(req_size),
    .req_offset(req_offset), .req_ready(req_ready), .ap_ack(ap_ack),
    .ap_valid(ap_valid), .ap_kind(ap_kind), .ap_ad(ap_ad), .ap_cmd(ap_cmd),
    .ap_be(ap_be)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent reference model
  function automatic logic [1:0] m_kind(input logic [31:0] c);
    if (c[31] == 1'b0) return 2'd3;
    if (c[15:11] == 5'd31) return 2'd2;
    if (c[23:16] == 8'd0) return 2'd0;
    return 2'd1;
  endfunction

  function automatic logic [31:0] m_ad(input logic [31:0] c);
    logic [31:0] r;
    int d;
    d = int'(c[15:11]);
    case (m_kind(c))
      2'd0: begin
        r = (32'(c[10:8]) * 256) + (32'(c[7:2]) * 4);
        if (d >= 10 && d <= 30) r = r | (32'h8000_0000 >> (d - 10));
      end
      2'd1: r = (c & 32'h00FF_FFFC) + 32'd1;
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] m_be(input logic [1:0] s, input logic [1:0] o);
    if (s == 2'd0) return 4'(1 << o);
    if (s == 2'd1) return (o >= 2) ? 4'd12 : 4'd3;
    return 4'd15;
  endfunction

  function automatic logic [3:0] m_cmd(input logic [31:0] c, input logic w);
    if (m_kind(c) >= 2'd2) return 4'd0;
    return w ? 4'd11 : 4'd10;
  endfunction

  function automatic string req_of(input logic [31:0] c);
    case (m_kind(c))
      2'd0: return "R5/R6";
      2'd1: return "R7";
      2'd2: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic txn(input logic [31:0] c, input logic w, input logic [1:0] s, input logic [1:0] o);
    logic [31:0] h_ad;
    logic [3:0]  h_cmd, h_be;
    logic [1:0]  h_kind;
    @(negedge clk);
    cfg_addr = c; req_write = w; req_io_win = 1'b1; req_size = s; req_offset = o;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "valid after accept", 32'(ap_valid), 32'd1);
    chk(req_of(c), "kind", 32'(ap_kind), 32'(m_kind(c)));
    chk(req_of(c), "ad", ap_ad, m_ad(c));
    chk("R8", "cmd", 32'(ap_cmd), 32'(m_cmd(c, w)));
    chk("R9", "be", 32'(ap_be), 32'(m_be(s, o)));
    h_ad = ap_ad; h_cmd = ap_cmd; h_be = ap_be; h_kind = ap_kind;
    // Offer a different request while busy; it must be dropped
    cfg_addr = ~c; req_write = ~w; req_size = s + 2'd1; req_valid = 1'b1;
    @(negedge clk);
    chk("R10", "held ad", ap_ad, h_ad);
    chk("R10", "held cmd/be/kind", {22'h0, h_kind, h_cmd, h_be} ^ {22'h0, ap_kind, ap_cmd, ap_be}, 32'h0);
    // Acknowledge and a new request in the same cycle
    ap_ack = 1'b1;
    @(negedge clk);
    ap_ack = 1'b0; req_valid = 1'b0;
    chk("R10", "valid after ack", 32'(ap_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid", 32'(ap_valid), 32'd0);
    chk("R1", "outputs", ap_ad | 32'(ap_kind) | 32'(ap_cmd) | 32'(ap_be), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: memory window access ignored
    for (int k = 0; k < 4; k++) begin
      cfg_addr = 32'h8000_5000 | (32'(k) << 16); req_io_win = 1'b0; req_valid = 1'b1;
      req_size = 2'(k); req_offset = 2'(k);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", "valid after memory access", 32'(ap_valid), 32'd0);
    end

    // Sweep every device over local and remote buses
    for (int b = 0; b < 3; b++) begin
      for (int d = 0; d < 32; d++) begin
        logic [7:0] bus;
        logic [31:0] c;
        bus = (b == 0) ? 8'h00 : ((b == 1) ? 8'h5A : 8'hFF);
        c = 32'h8000_0000 | (32'(bus) << 16) | (32'(d) << 11) | (32'(d % 8) << 8)
            | (32'((d * 7 + b) % 64) << 2) | 32'(b & 3) | 32'h2A00_0000;
        txn(c, 1'((d + b) & 1), 2'(d % 4), 2'((d / 4) % 4));
      end
    end

    // R3: enable clear over several fields
    for (int k = 0; k < 8; k++)
      txn((32'(k) * 32'h0123_4567) & 32'h7FFF_FFFF, 1'(k & 1), 2'd2, 2'd0);

    // R9: full size/offset sweep on a Type 0 and a Type 1 target
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++) begin
        txn(32'h8000_5324, 1'b0, 2'(s), 2'(o));
        txn(32'h8011_2A1C, 1'b1, 2'(s), 2'(o));
      end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule